// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block sits on the host side of a three-wire link to a 14-bit sampling converter. From the system clock it derives an active-low chip-select and a data clock, whose half-period is a whole number of system cycles. A start request pulls chip-select low. That one edge both begins the conversion and opens the data transfer. The controller then lets the sampling clocks and the null bit pass without capturing them. It collects the fourteen result bits, most significant first, on the rising data-clock edges. The converter changes its line on the falling edges. After the frame the controller releases chip-select, which puts the converter into full power-down. It presents the two's-complement result sign-extended to the output width, together with a one-cycle valid strobe.

A verify mode can be chosen per conversion. In that mode the controller keeps clocking after the two pad bits and gathers the replayed word, which the converter sends least significant bit first. It compares the replay with the first word. Any difference raises a sticky flag. The divider parameter is checked at elaboration so that each half-period lies between 200 ns and 20833 ns at the stated system clock.

Top module: `sar_serial_reader`

## Requirements
- R1: While reset is held, and in the cycles after it, chip-select is high, the data clock is low, valid is low, the mismatch flag is low and the result is zero. Busy stays high for exactly 2*HALF_DIV cycles after reset and then falls.
- R2: A start accepted while busy is low drives chip-select low in the next cycle. The first rising data-clock edge follows HALF_DIV cycles later, and each clock level then lasts HALF_DIV system cycles.
- R3: Whenever chip-select is high, the data clock is held low.
- R4: Counting rising data-clock edges from 1 after chip-select falls, edges 7 to 20 capture the fourteen result bits, most significant first, from the serial input.
- R5: With verify off, a frame has exactly 22 rising edges. Chip-select rises in the same cycle as the 22nd falling edge.
- R6: The result is the 14-bit word sign-extended to 16 bits. Valid is a single-cycle pulse in the first cycle that chip-select is high after a frame.
- R7: With verify on, a frame has exactly 37 rising edges. Edges 24 to 37 capture the replay with the least significant bit first. A replay equal to the first word leaves the mismatch flag unchanged.
- R8: A replay that differs from the first word sets the mismatch flag together with valid. The flag then stays set until reset, and the result still shows the first word.
- R9: A start is ignored while busy is high. Busy stays high until chip-select has been high for 2*HALF_DIV cycles. With start held high, chip-select falls again exactly 2*HALF_DIV+1 cycles after the valid cycle.
- R10: The serial input level at rising edges 1 to 6 and 21 to 23, and at edges 24 to 37 when verify is off, has no effect on the result or on the mismatch flag.
- R11: The verify input is sampled only when a start is accepted. Changing it during a frame does not alter that frame's length or checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, taken when busy is low |
| verify_i | input | 1 | Select the replay-compare frame for the next conversion |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip-select to the converter |
| sclk_o | output | 1 | Data clock to the converter |
| busy_o | output | 1 | Frame or power-down guard in progress |
| result_o | output | OUT_W (16) | Sign-extended conversion result |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |
| mismatch_o | output | 1 | Sticky replay mismatch flag |

## Verification
Two events can fall in the same cycle or on adjacent cycles: the end of a frame, with its valid strobe and the release of chip-select, and a new start request. The bench holds start high across the frame boundary and also pokes start in the middle of a frame. It then judges that the held request does not cut the frame short and does not shorten the power-down interval, and that chip-select falls again at exactly the cycle the guard allows. The same frame-end cycle is also where the mismatch flag and the valid strobe update together. The bench checks both at the valid cycle, for frames with a corrupted replay bit and for frames without one.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_GUARD = 2'd2
  } seq_state_e;

  // Rising-edge numbering inside a frame, counted from 1 after chip-select falls.
  function automatic int edge_msb_first(int sample_clks);
    return sample_clks + 2;              // sampling edges, then the null bit
  endfunction

  function automatic int edge_msb_last(int sample_clks, int data_w);
    return edge_msb_first(sample_clks) + data_w - 1;
  endfunction

  function automatic int edge_norm_last(int sample_clks, int data_w);
    return edge_msb_last(sample_clks, data_w) + 2;   // two pad bits
  endfunction

  function automatic int edge_rep_first(int sample_clks, int data_w);
    return edge_norm_last(sample_clks, data_w) + 2;  // leading zero of replay
  endfunction

  function automatic int edge_rep_last(int sample_clks, int data_w);
    return edge_rep_first(sample_clks, data_w) + data_w - 1;
  endfunction

endpackage

// File: rtl/sar_rd_clkgen.sv
module sar_rd_clkgen #(
  parameter int HALF_DIV    = 20,
  parameter int SYS_CLK_MHZ = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF_NS     = (HALF_DIV * 1000) / SYS_CLK_MHZ;
  localparam int MIN_HALF_NS = 200;
  localparam int MAX_HALF_NS = 20833;
  localparam int CNT_W       = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  generate
    if (HALF_DIV < 1 || HALF_NS < MIN_HALF_NS || HALF_NS > MAX_HALF_NS) begin : g_bad_div
      $error("sar_rd_clkgen: HALF_DIV gives a half-period outside 200..20833 ns");
    end
  endgenerate

  logic [CNT_W-1:0] div_cnt;
  logic             terminal;

  assign terminal = run && (div_cnt == CNT_LAST);
  assign rise_evt = terminal && !sclk;
  assign fall_evt = terminal && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
    end else if (terminal) begin
      div_cnt <= '0;
      sclk    <= ~sclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int HALF_DIV    = 20,
  parameter int DATA_W      = 14,
  parameter int SAMPLE_CLKS = 5,
  parameter int IDX_W       = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             verify,
  input  logic             rise_evt,
  input  logic             fall_evt,
  output logic             cs_n,
  output logic             run,
  output logic             busy,
  output logic             verify_q,
  output logic [IDX_W-1:0] edge_idx,
  output logic             frame_start,
  output logic             done
);
  localparam int GUARD_CYC = 2 * HALF_DIV;
  localparam int GCNT_W    = $clog2(GUARD_CYC + 1);
  localparam logic [GCNT_W-1:0] GUARD_LAST = GCNT_W'(GUARD_CYC - 1);
  localparam logic [IDX_W-1:0]  LAST_NORM  = IDX_W'(edge_norm_last(SAMPLE_CLKS, DATA_W));
  localparam logic [IDX_W-1:0]  LAST_VER   = IDX_W'(edge_rep_last(SAMPLE_CLKS, DATA_W));

  seq_state_e        state;
  logic [IDX_W-1:0]  rise_cnt;
  logic [GCNT_W-1:0] guard_cnt;
  logic [IDX_W-1:0]  last_edge;

  assign last_edge   = verify_q ? LAST_VER : LAST_NORM;
  assign run         = (state == SEQ_RUN);
  assign busy        = (state != SEQ_IDLE);
  assign frame_start = (state == SEQ_IDLE) && start;
  assign done        = run && fall_evt && (rise_cnt == last_edge);
  assign edge_idx    = rise_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_GUARD;
      cs_n      <= 1'b1;
      rise_cnt  <= '0;
      guard_cnt <= '0;
      verify_q  <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state    <= SEQ_RUN;
            cs_n     <= 1'b0;
            rise_cnt <= '0;
            verify_q <= verify;
          end
        end
        SEQ_RUN: begin
          if (rise_evt) rise_cnt <= rise_cnt + 1'b1;
          if (done) begin
            state     <= SEQ_GUARD;
            cs_n      <= 1'b1;
            guard_cnt <= '0;
          end
        end
        SEQ_GUARD: begin
          if (guard_cnt == GUARD_LAST) state <= SEQ_IDLE;
          else guard_cnt <= guard_cnt + 1'b1;
        end
        default: state <= SEQ_GUARD;
      endcase
    end
  end
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture
  import sar_rd_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int OUT_W       = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int IDX_W       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_evt,
  input  logic [IDX_W-1:0]  edge_idx,
  input  logic              sdo,
  input  logic              frame_start,
  input  logic              done,
  input  logic              verify_q,
  output logic [OUT_W-1:0]  result,
  output logic              valid,
  output logic              mismatch
);
  localparam logic [IDX_W-1:0] MSB_FIRST = IDX_W'(edge_msb_first(SAMPLE_CLKS));
  localparam logic [IDX_W-1:0] MSB_LAST  = IDX_W'(edge_msb_last(SAMPLE_CLKS, DATA_W));
  localparam logic [IDX_W-1:0] REP_FIRST = IDX_W'(edge_rep_first(SAMPLE_CLKS, DATA_W));
  localparam logic [IDX_W-1:0] REP_LAST  = IDX_W'(edge_rep_last(SAMPLE_CLKS, DATA_W));

  logic [DATA_W-1:0] msb_word;
  logic [DATA_W-1:0] lsb_word;
  logic [OUT_W-1:0]  msb_ext;
  logic              in_msb_win;
  logic              in_rep_win;

  assign in_msb_win = (edge_idx >= MSB_FIRST) && (edge_idx <= MSB_LAST);
  assign in_rep_win = verify_q && (edge_idx >= REP_FIRST) && (edge_idx <= REP_LAST);

  generate
    if (OUT_W > DATA_W) begin : g_sext
      assign msb_ext = {{(OUT_W - DATA_W){msb_word[DATA_W-1]}}, msb_word};
    end else begin : g_plain
      assign msb_ext = msb_word[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_word <= '0;
      lsb_word <= '0;
      result   <= '0;
      valid    <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      valid <= done;
      if (frame_start) begin
        msb_word <= '0;
        lsb_word <= '0;
      end else if (rise_evt) begin
        if (in_msb_win) msb_word <= {msb_word[DATA_W-2:0], sdo};
        if (in_rep_win) lsb_word <= {sdo, lsb_word[DATA_W-1:1]};
      end
      if (done) begin
        result <= msb_ext;
        if (verify_q && (lsb_word != msb_word)) mismatch <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_serial_reader.sv
module sar_serial_reader
  import sar_rd_pkg::*;
#(
  parameter int HALF_DIV    = 20,
  parameter int SYS_CLK_MHZ = 100,
  parameter int DATA_W      = 14,
  parameter int OUT_W       = 16,
  parameter int SAMPLE_CLKS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             verify_i,
  input  logic             sdo_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic [OUT_W-1:0] result_o,
  output logic             result_valid_o,
  output logic             mismatch_o
);
  localparam int IDX_W = $clog2(edge_rep_last(SAMPLE_CLKS, DATA_W) + 2);

  logic             run;
  logic             rise_evt;
  logic             fall_evt;
  logic             verify_q;
  logic [IDX_W-1:0] edge_idx;
  logic             frame_start;
  logic             done;

  sar_rd_clkgen #(
    .HALF_DIV   (HALF_DIV),
    .SYS_CLK_MHZ(SYS_CLK_MHZ)
  ) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .sclk    (sclk_o),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt)
  );

  sar_rd_seq #(
    .HALF_DIV   (HALF_DIV),
    .DATA_W     (DATA_W),
    .SAMPLE_CLKS(SAMPLE_CLKS),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .verify     (verify_i),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .cs_n       (cs_n_o),
    .run        (run),
    .busy       (busy_o),
    .verify_q   (verify_q),
    .edge_idx   (edge_idx),
    .frame_start(frame_start),
    .done       (done)
  );

  sar_rd_capture #(
    .DATA_W     (DATA_W),
    .OUT_W      (OUT_W),
    .SAMPLE_CLKS(SAMPLE_CLKS),
    .IDX_W      (IDX_W)
  ) u_capture (
    .clk        (clk),
    .rst        (rst),
    .rise_evt   (rise_evt),
    .edge_idx   (edge_idx),
    .sdo        (sdo_i),
    .frame_start(frame_start),
    .done       (done),
    .verify_q   (verify_q),
    .result     (result_o),
    .valid      (result_valid_o),
    .mismatch   (mismatch_o)
  );
endmodule

// File: rtl/sar_serial_reader_chk.sv
module sar_serial_reader_chk
  import sar_rd_pkg::*;
#(
  parameter int HALF_DIV    = 20,
  parameter int DATA_W      = 14,
  parameter int OUT_W       = 16,
  parameter int SAMPLE_CLKS = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             busy_o,
  input logic [OUT_W-1:0] result_o,
  input logic             result_valid_o,
  input logic             mismatch_o
);
  localparam logic [31:0] GAP       = 32'(2 * HALF_DIV);
  localparam logic [7:0]  NORM_EDGE = 8'(edge_norm_last(SAMPLE_CLKS, DATA_W));
  localparam logic [7:0]  VER_EDGE  = 8'(edge_rep_last(SAMPLE_CLKS, DATA_W));

  logic [31:0] hi_cnt;
  logic [7:0]  rise_cnt;
  logic        cs_q;
  logic        sk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      rise_cnt <= '0;
      cs_q     <= 1'b1;
      sk_q     <= 1'b0;
    end else begin
      cs_q <= cs_n_o;
      sk_q <= sclk_o;
      if (!cs_n_o) hi_cnt <= '0;
      else if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1'b1;
      if (cs_q && !cs_n_o) rise_cnt <= '0;
      else if (sclk_o && !sk_q && rise_cnt != 8'hFF) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_sclk_parked_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  assert_start_needed_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $past(start_i && !busy_o));

  assert_power_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (hi_cnt >= GAP));

  assert_busy_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> busy_o);

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> (rise_cnt == NORM_EDGE || rise_cnt == VER_EDGE));

  assert_rise_bound_R7: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> (rise_cnt <= VER_EDGE));

  assert_valid_at_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> result_valid_o);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |=> !result_valid_o);

  assert_sign_ext_R6: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> ((&result_o[OUT_W-1:DATA_W-1]) || !(|result_o[OUT_W-1:DATA_W-1])));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    mismatch_o |=> mismatch_o);
endmodule

bind sar_serial_reader sar_serial_reader_chk #(
  .HALF_DIV   (HALF_DIV),
  .DATA_W     (DATA_W),
  .OUT_W      (OUT_W),
  .SAMPLE_CLKS(SAMPLE_CLKS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .cs_n_o        (cs_n_o),
  .sclk_o        (sclk_o),
  .busy_o        (busy_o),
  .result_o      (result_o),
  .result_valid_o(result_valid_o),
  .mismatch_o    (mismatch_o)
);

// File: tb/tb_sar_serial_reader.sv
`timescale 1ns/1ps
module tb_sar_serial_reader;
  localparam int HALF_DIV = 20;
  localparam int GAP      = 2 * HALF_DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        verify_i = 1'b0;
  logic        sdo_i = 1'b0;
  logic        cs_n_o, sclk_o, busy_o, result_valid_o, mismatch_o;
  logic [15:0] result_o;

  int errors = 0;
  int checks = 0;
  int rises  = 0;
  int fcnt   = 0;
  logic [13:0] model_word = '0;
  int          corrupt_idx = -1;
  bit          exp_err = 1'b0;

  always #5 clk = ~clk;

  sar_serial_reader #(.HALF_DIV(HALF_DIV), .SYS_CLK_MHZ(100)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .verify_i(verify_i), .sdo_i(sdo_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o), .result_o(result_o),
    .result_valid_o(result_valid_o), .mismatch_o(mismatch_o));

  // Converter model: changes its line on falling clock edges; non-data slots carry junk (R10).
  function automatic logic slot_bit(int f);
    if (f >= 6 && f <= 19) return model_word[13 - (f - 6)];
    if (f >= 23 && f <= 36) return model_word[f - 23] ^ ((f - 23) == corrupt_idx);
    return 1'($urandom);
  endfunction

  always @(negedge cs_n_o) begin fcnt = 0; sdo_i = 1'($urandom); end
  always @(posedge cs_n_o) sdo_i = 1'($urandom);
  always @(negedge sclk_o) if (!cs_n_o) begin fcnt = fcnt + 1; sdo_i = slot_bit(fcnt); end
  always @(posedge sclk_o) if (!cs_n_o) rises = rises + 1;

  function automatic logic [15:0] sext(logic [13:0] w);
    return {{2{w[13]}}, w};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic wait_valid();
    while (!result_valid_o) @(negedge clk);
  endtask

  // One conversion; checks timing, length, result and flag.
  task automatic run_frame(logic [13:0] w, bit ver, int corrupt, bit flip_ver, bit poke);
    int n;
    while (busy_o) @(negedge clk);
    model_word = w; corrupt_idx = corrupt; rises = 0;
    verify_i = ver; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R2 cs low after start", 32'(cs_n_o), 0);
    n = 0;
    while (!sclk_o && n < 4 * HALF_DIV) begin @(negedge clk); n++; end
    chk("R2 first rise delay", n, HALF_DIV);
    n = 0;
    while (sclk_o && n < 4 * HALF_DIV) begin @(negedge clk); n++; end
    chk("R2 high level length", n, HALF_DIV);
    if (flip_ver) verify_i = !ver;         // R11
    if (poke) begin start_i = 1'b1; @(negedge clk); start_i = 1'b0; end  // R9
    wait_valid();
    if (ver && corrupt >= 0) exp_err = 1'b1;
    chk("R4 R6 R10 result", 32'(result_o), 32'(sext(w)));
    chk("R6 cs high at valid", 32'(cs_n_o), 1);
    chk(ver ? "R7 edge count" : "R5 edge count", rises, ver ? 37 : 22);
    chk(ver ? "R7 R8 mismatch flag" : "R10 mismatch flag", 32'(mismatch_o), 32'(exp_err));
    @(negedge clk);
    chk("R6 valid pulse", 32'(result_valid_o), 0);
    if (poke) begin
      n = 0;
      while (cs_n_o && n < GAP + 6) begin @(negedge clk); n++; end
      chk("R9 ignored start", n, GAP + 6);
    end
    verify_i = 1'b0;
  endtask

  initial begin
    int n;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk("R1 cs in reset", 32'(cs_n_o), 1);
    chk("R1 sclk in reset", 32'(sclk_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", 32'(result_valid_o), 0);
    chk("R1 flag after reset", 32'(mismatch_o), 0);
    chk("R1 result after reset", 32'(result_o), 0);
    n = 1;
    while (busy_o && n < 4 * GAP) begin @(negedge clk); n++; end
    chk("R1 busy after reset", n, GAP);
    chk("R3 sclk parked", 32'(sclk_o), 0);

    // Directed corner words, normal frames
    run_frame(14'h1FFF, 0, -1, 0, 0);
    run_frame(14'h0000, 0, -1, 0, 0);
    run_frame(14'h2000, 0, -1, 0, 0);
    run_frame(14'h3FFF, 0, -1, 0, 0);
    run_frame(14'h0001, 0, -1, 0, 0);
    // Verify mode, matching replay (R7)
    run_frame(14'h1555, 1, -1, 0, 0);
    run_frame(14'h2AAA, 1, -1, 0, 0);
    // Corrupt replay in normal mode is not looked at (R10)
    run_frame(14'h0F0F, 0, 3, 0, 0);
    // verify_i changes mid-frame (R11)
    run_frame(14'h1234, 0, -1, 1, 0);
    run_frame(14'h2345, 1, -1, 1, 0);
    // Start poked mid-frame (R9)
    run_frame(14'h0ACE, 0, -1, 0, 1);

    // Start held high across the frame boundary (R9)
    while (busy_o) @(negedge clk);
    model_word = 14'h3C3C; corrupt_idx = -1; rises = 0;
    start_i = 1'b1;
    wait_valid();
    chk("R9 held start edge count", rises, 22);
    chk("R9 busy at valid", 32'(busy_o), 1);
    n = 0;
    while (cs_n_o && n < 4 * GAP) begin @(negedge clk); n++; end
    chk("R9 restart gap", n, GAP + 1);
    start_i = 1'b0; rises = 0;
    wait_valid();
    chk("R9 second result", 32'(result_o), 32'(sext(14'h3C3C)));
    @(negedge clk);

    // Corrupted replay sets the sticky flag (R8)
    run_frame(14'h1357, 1, 0, 0, 0);
    run_frame(14'h0246, 0, -1, 0, 0);
    chk("R8 flag held", 32'(mismatch_o), 1);

    // Random frames
    for (int i = 0; i < 16; i++) begin
      logic [13:0] w;
      bit v;
      w = 14'($urandom);
      v = 1'($urandom);
      run_frame(w, v, (($urandom % 4) == 0) ? int'($urandom % 14) : -1, 1'($urandom), 0);
    end
    summary();
  end
endmodule